// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block sits on a half-duplex serial bus with a clock, an active-low select and a single shared data wire. The bus master shifts a command byte in, and the slave either accepts a data byte or, after one idle turnaround clock, sends a data byte back on the same wire. The shared wire is split at the block boundary into an input, an output and an output enable, so the pad cell stays outside.

Behind the bus sits a four-entry register file. It holds a scratch register for link testing, a fixed identification byte, a resolution selector and a power/ownership register. The block outputs a 3-bit resolution code and a standby flag. These come from the software registers once the ownership bit is set, and from two strap inputs otherwise.

The bus pins are oversampled by the system clock through synchronisers, so the serial clock must be several times slower than the system clock. A frame must also last at least a few system clocks per serial clock phase.

Top module: `spi3w_regslave`

## Requirements
- R1: A write frame has 16 serial clocks. Bits are sampled on the rising serial clock edge, MSB first. Bits 1..6 are the register address, bit 7 is the command bit (0 = write), bit 8 is a pad bit, and bits 9..16 are the data. The register changes once, when the 16th rising edge is seen.
- R2: A read frame has 6 address bits, then a command bit of 1, then one turnaround clock in which the output enable stays low. The slave then drives 8 data bits MSB first, changing after each falling edge. The output enable is high only from the falling edge after the 8th rising edge until the falling edge after the 16th.
- R3: Address 0 is a scratch register. Reading it returns the last byte written to it, including 0x55.
- R4: Address 1 is read-only. It returns {ID nibble, version nibble}, which is 0xA3 with the default parameters, and writes to it have no effect.
- R5: Address 2 keeps the written bits 2:0 as the resolution code and reads back with bits 7:3 as zero. Its reset value is 3'd7.
- R6: At address 3, bit 0 is the power bit (1 = active) and bit 7 is the ownership bit (1 = software). The other bits read as zero, and the reset value is 0x00.
- R7: When the ownership bit is 1, `res_code_o` equals register 2 bits 2:0 and `standby_o` is the inverse of register 3 bit 0. When it is 0, `res_code_o` equals `strap_res_i` and `standby_o` is the inverse of `strap_active_i`.
- R8: If the select goes high before the 16th rising edge, the frame is dropped and no register changes. The output enable is low whenever the select is high.
- R9: Addresses 4 to 63 are unmapped. Writes to them change nothing, and reads return 0x00.
- R10: A low `rst_n` returns all registers to their reset values and the output enable to low.
- R11: Serial clocks beyond the 16th in one frame are ignored. They cause no second write, and the output enable stays low during them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk_i | input | 1 | Serial clock from the bus master |
| csn_i | input | 1 | Active-low frame select |
| sdio_i | input | 1 | Shared data wire, input side |
| sdio_o | output | 1 | Shared data wire, output side |
| sdio_oe_o | output | 1 | Output enable for the shared data wire |
| strap_res_i | input | 3 | Resolution code from board straps |
| strap_active_i | input | 1 | Power strap, 1 = active |
| res_code_o | output | 3 | Resolution code in effect |
| standby_o | output | 1 | Standby request, 1 = standby |

## Verification
The bench checks the turnaround clock and the clocks after the 16th, where the output enable must stay low. A slave that drove early would collide with the master on the wire, and one that drove late would shift every read byte. It drops the select in the middle of both write and read frames. A design that committed a write on a partial frame would corrupt the scratch register, and one that kept driving would hold the wire after the select was released. It sweeps all unmapped addresses and writes the read-only ID and the masked bits. A decoder that aliased addresses, or kept the unused bits, would show up as changed read-back values or as a moved resolution output.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  localparam int unsigned ADDR_W     = 6;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned FRAME_BITS = 2 * DATA_W;
  localparam int unsigned RES_W      = 3;

  localparam logic [ADDR_W-1:0] REG_TEST = 6'd0;
  localparam logic [ADDR_W-1:0] REG_ID   = 6'd1;
  localparam logic [ADDR_W-1:0] REG_RES  = 6'd2;
  localparam logic [ADDR_W-1:0] REG_PWR  = 6'd3;

  localparam int unsigned PWR_ACTIVE_BIT = 0;
  localparam int unsigned SRC_SW_BIT     = 7;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/spi3w_sync.sv
module spi3w_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi3w_frame.sv
module spi3w_frame
  import spi3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output wr_req_t           wr_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int unsigned CNT_W   = $clog2(FRAME_BITS + 1);
  localparam int unsigned SHIFT_W = DATA_W - 1;
  localparam logic [CNT_W-1:0] C_CMD  = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] C_TURN = CNT_W'(ADDR_W + 2);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] C_END  = CNT_W'(FRAME_BITS);

  logic               sclk_q, sclk_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [SHIFT_W-1:0] shift_q, shift_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic               rd_q, rd_d;
  logic [DATA_W-1:0]  tx_q, tx_d;
  logic               sdo_q, sdo_d;
  logic               oe_q, oe_d;
  logic               wen_q, wen_d;
  logic [DATA_W-1:0]  wdat_q, wdat_d;
  logic               rise, fall;

  assign rise = sclk_s & ~sclk_q;
  assign fall = ~sclk_s & sclk_q;

  always_comb begin
    sclk_d  = sclk_s;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    addr_d  = addr_q;
    rd_d    = rd_q;
    tx_d    = tx_q;
    sdo_d   = sdo_q;
    oe_d    = oe_q;
    wen_d   = 1'b0;
    wdat_d  = wdat_q;
    if (csn_s) begin
      cnt_d = '0;
      oe_d  = 1'b0;
      rd_d  = 1'b0;
    end else begin
      if (rise && (cnt_q < C_END)) begin
        shift_d = {shift_q[SHIFT_W-2:0], sdi_s};
        cnt_d   = cnt_q + 1'b1;
        if (cnt_q == C_CMD) begin
          addr_d = shift_q[ADDR_W-1:0];
          rd_d   = sdi_s;
          tx_d   = rd_data_i;
        end
        if ((cnt_q == C_LAST) && !rd_q) begin
          wen_d  = 1'b1;
          wdat_d = {shift_q, sdi_s};
        end
      end
      if (fall) begin
        if (rd_q && (cnt_q >= C_TURN) && (cnt_q < C_END)) begin
          oe_d  = 1'b1;
          sdo_d = tx_q[DATA_W-1];
          tx_d  = {tx_q[DATA_W-2:0], 1'b0};
        end else begin
          oe_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cnt_q   <= '0;
      shift_q <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      tx_q    <= '0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
      wen_q   <= 1'b0;
      wdat_q  <= '0;
    end else begin
      sclk_q  <= sclk_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      addr_q  <= addr_d;
      rd_q    <= rd_d;
      tx_q    <= tx_d;
      sdo_q   <= sdo_d;
      oe_q    <= oe_d;
      wen_q   <= wen_d;
      wdat_q  <= wdat_d;
    end
  end

  assign rd_addr_o = shift_q[ADDR_W-1:0];
  assign wr_o      = '{en: wen_q, addr: addr_q, data: wdat_q};
  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = oe_q;
endmodule

// File: rtl/spi3w_regs.sv
module spi3w_regs
  import spi3w_pkg::*;
#(
  parameter logic [3:0]       CHIP_ID  = 4'hA,
  parameter logic [3:0]       CHIP_VER = 4'h3,
  parameter logic [RES_W-1:0] RES_RST  = 3'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_req_t           wr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [RES_W-1:0]  strap_res_i,
  input  logic              strap_active_i,
  output logic [RES_W-1:0]  res_code_o,
  output logic              standby_o
);
  logic [DATA_W-1:0] scratch_q, scratch_d;
  logic [RES_W-1:0]  res_q, res_d;
  logic              pwr_q, pwr_d;
  logic              src_q, src_d;

  always_comb begin
    scratch_d = scratch_q;
    res_d     = res_q;
    pwr_d     = pwr_q;
    src_d     = src_q;
    if (wr_i.en) begin
      case (wr_i.addr)
        REG_TEST: scratch_d = wr_i.data;
        REG_RES:  res_d     = wr_i.data[RES_W-1:0];
        REG_PWR: begin
          pwr_d = wr_i.data[PWR_ACTIVE_BIT];
          src_d = wr_i.data[SRC_SW_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      res_q     <= RES_RST;
      pwr_q     <= 1'b0;
      src_q     <= 1'b0;
    end else begin
      scratch_q <= scratch_d;
      res_q     <= res_d;
      pwr_q     <= pwr_d;
      src_q     <= src_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      REG_TEST: rd_data_o = scratch_q;
      REG_ID:   rd_data_o = {CHIP_ID, CHIP_VER};
      REG_RES:  rd_data_o[RES_W-1:0] = res_q;
      REG_PWR: begin
        rd_data_o[PWR_ACTIVE_BIT] = pwr_q;
        rd_data_o[SRC_SW_BIT]     = src_q;
      end
      default: rd_data_o = '0;
    endcase
  end

  assign res_code_o = src_q ? res_q : strap_res_i;
  assign standby_o  = src_q ? ~pwr_q : ~strap_active_i;
endmodule

// File: rtl/spi3w_regslave.sv
module spi3w_regslave
  import spi3w_pkg::*;
#(
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [3:0]       CHIP_ID     = 4'hA,
  parameter logic [3:0]       CHIP_VER    = 4'h3,
  parameter logic [RES_W-1:0] RES_RST     = 3'd7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             csn_i,
  input  logic             sdio_i,
  output logic             sdio_o,
  output logic             sdio_oe_o,
  input  logic [RES_W-1:0] strap_res_i,
  input  logic             strap_active_i,
  output logic [RES_W-1:0] res_code_o,
  output logic             standby_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n_int;
  logic [2:0]        pins_s;
  logic              sclk_s, csn_s, sdi_s;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  wr_req_t           wr_req;
  logic              wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  spi3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .d_i  ({sclk_i, csn_i, sdio_i}),
    .q_o  (pins_s)
  );
  assign {sclk_s, csn_s, sdi_s} = pins_s;

  spi3w_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .sclk_s   (sclk_s),
    .csn_s    (csn_s),
    .sdi_s    (sdi_s),
    .rd_data_i(rd_data),
    .rd_addr_o(rd_addr),
    .wr_o     (wr_req),
    .sdo_o    (sdio_o),
    .sdo_oe_o (sdio_oe_o)
  );
  assign wr_en = wr_req.en;

  spi3w_regs #(.CHIP_ID(CHIP_ID), .CHIP_VER(CHIP_VER), .RES_RST(RES_RST)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .wr_i          (wr_req),
    .rd_addr_i     (rd_addr),
    .rd_data_o     (rd_data),
    .strap_res_i   (strap_res_i),
    .strap_active_i(strap_active_i),
    .res_code_o    (res_code_o),
    .standby_o     (standby_o)
  );
endmodule

// File: rtl/spi3w_regslave_chk.sv
module spi3w_regslave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       csn_s,
  input logic       wr_en,
  input logic       sdio_oe_o,
  input logic [2:0] strap_res_i,
  input logic       strap_active_i,
  input logic [2:0] res_code_o,
  input logic       standby_o
);
  // R1: a commit is a single-cycle pulse
  assert_wr_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R2: the slave never drives while a write is committed
  assert_no_wr_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe_o |-> !wr_en);

  // R8: a deselected bus releases the wire
  assert_oe_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !sdio_oe_o);

  // R7: outputs move only on a commit or a strap change
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!($stable(strap_res_i) && $stable(strap_active_i)) ||
                ($stable(res_code_o) && $stable(standby_o))));
endmodule

bind spi3w_regslave spi3w_regslave_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .csn_s         (csn_s),
  .wr_en         (wr_en),
  .sdio_oe_o     (sdio_oe_o),
  .strap_res_i   (strap_res_i),
  .strap_active_i(strap_active_i),
  .res_code_o    (res_code_o),
  .standby_o     (standby_o)
);

// File: tb/spi3w_regslave_tb.sv
module spi3w_regslave_tb;
  localparam int HP = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, sclk, csn, sdi, sdo, oe, standby, strap_act;
  logic [2:0] strap_res, res_code;
  int n_chk = 0, n_err = 0;
  bit oe_stray = 0;
  bit done = 0;

  spi3w_regslave u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdio_i(sdi),
    .sdio_o(sdo), .sdio_oe_o(oe), .strap_res_i(strap_res),
    .strap_active_i(strap_act), .res_code_o(res_code), .standby_o(standby)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic sbit(logic b);
    sdi = b;
    tick(HP);
    if (oe) oe_stray = 1;
    sclk = 1'b1;
    tick(HP);
    sclk = 1'b0;
  endtask

  task automatic wr_frame(logic [5:0] a, logic [7:0] d, int extra = 0);
    csn = 1'b0;
    tick(HP);
    for (int i = 5; i >= 0; i--) sbit(a[i]);
    sbit(1'b0);
    sbit(1'b0);
    for (int i = 7; i >= 0; i--) sbit(d[i]);
    for (int i = 0; i < extra; i++) sbit(1'b1);
    tick(HP);
    csn = 1'b1;
    tick(2 * HP);
  endtask

  task automatic rd_frame(logic [5:0] a, int extra, output logic [7:0] d, output bit bad);
    bad = 0;
    d = '0;
    csn = 1'b0;
    tick(HP);
    for (int i = 5; i >= 0; i--) sbit(a[i]);
    sbit(1'b1);
    sdi = 1'b1;
    tick(HP);
    if (oe) bad = 1;
    sclk = 1'b1;
    tick(HP);
    sclk = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(HP);
      if (!oe) bad = 1;
      d[i] = sdo;
      sclk = 1'b1;
      tick(HP);
      sclk = 1'b0;
    end
    for (int i = 0; i < extra; i++) begin
      tick(HP);
      if (oe) bad = 1;
      sclk = 1'b1;
      tick(HP);
      sclk = 1'b0;
    end
    tick(HP);
    if (oe) bad = 1;
    csn = 1'b1;
    tick(2 * HP);
  endtask

  task automatic rd_chk(string tag, logic [5:0] a, logic [7:0] exp, int extra = 0);
    logic [7:0] d;
    bit bad;
    rd_frame(a, extra, d, bad);
    chk(tag, d, exp);
    chk({tag, " oe window"}, {7'd0, bad}, 8'd0);
  endtask

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; sclk = 1'b0; csn = 1'b1; sdi = 1'b0;
    strap_res = 3'd5; strap_act = 1'b1;
    tick(4);
    rst_n = 1'b1;
    tick(6);

    // R10 reset state; R7 straps in control
    chk("R10 oe after reset", {7'd0, oe}, 8'd0);
    chk("R7 res from strap", {5'd0, res_code}, 8'd5);
    chk("R7 standby from strap", {7'd0, standby}, 8'd0);
    rd_chk("R10 reg0 reset", 6'd0, 8'h00);
    rd_chk("R4 id value", 6'd1, 8'hA3);
    rd_chk("R5 reg2 reset", 6'd2, 8'h07);
    rd_chk("R6 reg3 reset", 6'd3, 8'h00);

    // R3 scratch sweep, R1 write frame format
    wr_frame(6'd0, 8'h55);
    rd_chk("R3 scratch 55", 6'd0, 8'h55);
    for (int i = 0; i < 16; i++) begin
      v = 8'((i * 37 + 11) % 256);
      wr_frame(6'd0, v);
      rd_chk("R1 R3 scratch sweep", 6'd0, v);
    end
    chk("R1 no drive in write frames", {7'd0, oe_stray}, 8'd0);

    // R4 read-only
    wr_frame(6'd1, 8'h00);
    rd_chk("R4 id after write", 6'd1, 8'hA3);

    // R5 resolution field masking
    for (int i = 0; i < 16; i++) begin
      v = (i[3]) ? (8'hF8 | 8'(i[2:0])) : 8'(i[2:0]);
      wr_frame(6'd2, v);
      rd_chk("R5 reg2 masked", 6'd2, {5'd0, v[2:0]});
    end
    chk("R7 strap still rules res", {5'd0, res_code}, 8'd5);

    // R6 R7 ownership and power bits
    wr_frame(6'd2, 8'h03);
    wr_frame(6'd3, 8'hFF);
    rd_chk("R6 reg3 masked", 6'd3, 8'h81);
    chk("R7 sw res", {5'd0, res_code}, 8'd3);
    chk("R7 sw active", {7'd0, standby}, 8'd0);
    strap_res = 3'd2; strap_act = 1'b0;
    tick(4);
    chk("R7 strap ignored res", {5'd0, res_code}, 8'd3);
    chk("R7 strap ignored stby", {7'd0, standby}, 8'd0);
    wr_frame(6'd3, 8'h80);
    chk("R7 sw standby", {7'd0, standby}, 8'd1);
    wr_frame(6'd3, 8'h01);
    rd_chk("R6 reg3 pwr only", 6'd3, 8'h01);
    chk("R7 back to strap res", {5'd0, res_code}, 8'd2);
    chk("R7 back to strap stby", {7'd0, standby}, 8'd1);

    // R9 unmapped addresses
    wr_frame(6'd0, 8'h3C);
    for (int a = 4; a < 64; a++) begin
      wr_frame(6'(a), 8'hFF);
      rd_chk("R9 unmapped read", 6'(a), 8'h00);
    end
    rd_chk("R9 reg0 intact", 6'd0, 8'h3C);
    rd_chk("R9 reg2 intact", 6'd2, 8'h03);
    rd_chk("R9 reg3 intact", 6'd3, 8'h01);

    // R8 aborted write
    csn = 1'b0;
    tick(HP);
    for (int i = 0; i < 8; i++) sbit(1'b0);
    for (int i = 0; i < 7; i++) sbit(1'b1);
    csn = 1'b1;
    tick(2 * HP);
    rd_chk("R8 aborted write", 6'd0, 8'h3C);

    // R8 aborted read releases the wire
    csn = 1'b0;
    tick(HP);
    for (int i = 0; i < 6; i++) sbit(1'b0);
    sbit(1'b1);
    for (int i = 0; i < 4; i++) begin
      tick(HP); sclk = 1'b1; tick(HP); sclk = 1'b0;
    end
    tick(2);
    chk("R8 driving mid read", {7'd0, oe}, 8'd1);
    csn = 1'b1;
    tick(HP);
    chk("R8 oe after abort", {7'd0, oe}, 8'd0);
    tick(HP);

    // R11 extra clocks
    wr_frame(6'd0, 8'hA5, 8);
    rd_chk("R11 extra write clocks", 6'd0, 8'hA5);
    rd_chk("R11 extra read clocks", 6'd0, 8'hA5, 6);

    // R10 reset restores defaults
    wr_frame(6'd3, 8'h81);
    tick(2);
    rst_n = 1'b0;
    tick(3);
    chk("R10 oe in reset", {7'd0, oe}, 8'd0);
    rst_n = 1'b1;
    tick(6);
    rd_chk("R10 reg0 after reset", 6'd0, 8'h00);
    rd_chk("R10 reg2 after reset", 6'd2, 8'h07);
    rd_chk("R10 reg3 after reset", 6'd3, 8'h00);
    chk("R10 res from strap", {5'd0, res_code}, 8'd2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule